// File: doc/BRIEF.md
# Externally Clocked Trigger Counter

This block is an up-counter that takes its count clock from a chosen external or internal signal rather than from the system clock. Sixteen candidate signals enter on one bus. A source-select field picks one. That signal passes through a two-flop resynchroniser, then through an optional digital glitch filter, and then through an edge detector that can be set to rising or falling edges. The resulting edge pulse advances the counter by exactly one, but only when four conditions hold together:

- the counter is enabled;
- the channel is configured as an input;
- the slave mode selects external clock mode 1;
- the trigger selector points at the filtered channel input.

Software reaches the block through a single-cycle write port and a combinational read port. The registers hold the channel configuration, the slave configuration, the run control bit, a trigger flag and the count value. Each counted edge sets the trigger flag. Software clears the flag by writing zero to it. The channel register also holds a capture prescaler field, which has no effect on the trigger path.

Top module: `ext_trig_counter`

## Requirements
- R1: After reset the count, the trigger flag and every configuration register read as zero.
- R2: Register map, where each written value reads back unchanged:
  - address 0 is control, with bit 0 as run enable;
  - address 1 is channel configuration, with [1:0] direction, [5:2] filter length, [6] polarity, [11:8] source select and [13:12] prescaler;
  - address 2 is slave configuration, with [2:0] slave mode and [8:4] trigger select;
  - address 3 is status, with bit 0 as the trigger flag;
  - address 4 is the count.
- R3: With polarity 0 and filter length 0, each rising input edge adds exactly one to the count. The new value appears at the fourth clock edge after the input change, which is the edge that samples it plus three.
- R4: With polarity 1, falling edges are counted with the same latency and rising edges are not counted.
- R5: With filter length N > 0, the input must hold a new level for N consecutive samples before it counts. A pulse N-1 samples wide is ignored. The latency grows by N cycles.
- R6: No edge is counted unless all of these hold together: run enable is 1, direction is 2'b01, slave mode is 3'b111 and trigger select is 5'b00110.
- R7: Source select picks bit [select] of the 16-bit source bus. Edges on the other source bits are ignored.
- R8: Each counted edge sets the trigger flag. Writing status with bit 0 equal to 0 clears the flag. Writing bit 0 equal to 1 leaves it unchanged.
- R9: The prescaler field has no effect: every qualified edge still counts once.
- R10: The count can be written. It wraps from 16'hFFFF to 0 on the next counted edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 16 | Candidate trigger sources, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| trig_flag | output | 1 | Trigger flag |
| count | output | 16 | Current count value |

## Verification
The assertions check several properties on every cycle:

- outside a software write, the count moves by at most one step;
- the count stays frozen while no edge qualifies;
- it wraps from all ones to zero;
- the flag rises only when the run enable is set, and is set after every counted edge;
- the filtered level only ever moves toward the value the synchroniser held on the previous cycle.

Only the bench scenarios can show the exact four-cycle latency and its growth with the filter length, and that narrow glitches are rejected. They also show the polarity choice, the isolation of unselected sources, each gating condition on its own, and that the prescaler field has no effect.

// File: rtl/ectc_pkg.sv
package ectc_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CHAN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_SLAVE  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;

    localparam logic [1:0] DIR_INPUT  = 2'b01;
    localparam logic [2:0] MODE_EXT1  = 3'b111;
    localparam logic [4:0] TSEL_CHAN  = 5'b00110;

    typedef struct packed {
        logic [1:0] rsvd_hi;
        logic [1:0] psc;
        logic [3:0] src;
        logic       rsvd_lo;
        logic       pol;
        logic [3:0] filt;
        logic [1:0] dir;
    } chan_cfg_t;

    typedef struct packed {
        logic [6:0] rsvd_hi;
        logic [4:0] tsel;
        logic       rsvd_lo;
        logic [2:0] mode;
    } slave_cfg_t;

    function automatic logic trig_qualified(input chan_cfg_t c, input slave_cfg_t s,
                                            input logic run);
        return run && (c.dir == DIR_INPUT) && (s.mode == MODE_EXT1)
                   && (s.tsel == TSEL_CHAN);
    endfunction

endpackage

// File: rtl/trig_regs.sv
module trig_regs
    import ectc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  ctrl_q,
    output chan_cfg_t         chan_q,
    output slave_cfg_t        slave_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            chan_q  <= '0;
            slave_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:  ctrl_q  <= wr_data;
                A_CHAN:  chan_q  <= chan_cfg_t'(wr_data);
                A_SLAVE: slave_q <= slave_cfg_t'(wr_data);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/trig_input.sv
module trig_input #(
    parameter int N_SRC  = 16,
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_in,
    input  logic [3:0]        src_sel,
    input  logic [FILT_W-1:0] filt_len,
    output logic              level
);

    localparam int SEL_W = $clog2(N_SRC);

    logic              meta_q, sync_q;
    logic              flev_q;
    logic [FILT_W-1:0] run_q;
    logic              picked;

    assign picked = src_in[src_sel[SEL_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= picked;
            sync_q <= meta_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flev_q <= 1'b0;
            run_q  <= '0;
        end else if (filt_len == '0) begin
            flev_q <= sync_q;
            run_q  <= '0;
        end else if (sync_q != flev_q) begin
            if (run_q == filt_len - 1'b1) begin
                flev_q <= sync_q;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign level = (filt_len == '0) ? sync_q : flev_q;

    // R5
    filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (flev_q != $past(flev_q)) |-> ($past(sync_q) == flev_q));

endmodule

// File: rtl/trig_edge.sv
module trig_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic pol,
    output logic edge_q
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            prev_q <= level;
            edge_q <= pol ? (prev_q & ~level) : (level & ~prev_q);
        end
    end

endmodule

// File: rtl/trig_count.sv
module trig_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (cnt_wr) begin
            count <= cnt_wdata;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (tick) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> (count == $past(count)) || (count == $past(count) + 1'b1));

    // R6
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && !tick) |=> $stable(count));

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> flag);

    // R10
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && tick && count == '1) |=> (count == '0));

endmodule

// File: rtl/ext_trig_counter.sv
module ext_trig_counter
    import ectc_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int CNT_W  = 16,
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              trig_flag,
    output logic [CNT_W-1:0]  count
);

    logic [REG_W-1:0] ctrl_q;
    chan_cfg_t        chan_q;
    slave_cfg_t       slave_q;
    logic             level, edge_q, tick;
    logic             cnt_wr, flag_clr;

    trig_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .chan_q  (chan_q),
        .slave_q (slave_q)
    );

    trig_input #(.N_SRC(N_SRC), .FILT_W(FILT_W)) u_input (
        .clk      (clk),
        .rst      (rst),
        .src_in   (src_in),
        .src_sel  (chan_q.src),
        .filt_len (chan_q.filt[FILT_W-1:0]),
        .level    (level)
    );

    trig_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .level  (level),
        .pol    (chan_q.pol),
        .edge_q (edge_q)
    );

    assign tick     = edge_q && trig_qualified(chan_q, slave_q, ctrl_q[0]);
    assign cnt_wr   = wr_en && (wr_addr == A_COUNT);
    assign flag_clr = wr_en && (wr_addr == A_STATUS) && !wr_data[0];

    trig_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (wr_data[CNT_W-1:0]),
        .flag_clr  (flag_clr),
        .count     (count),
        .flag      (trig_flag)
    );

    always_comb begin
        case (rd_addr)
            A_CTRL:   rd_data = ctrl_q;
            A_CHAN:   rd_data = chan_q;
            A_SLAVE:  rd_data = slave_q;
            A_STATUS: rd_data = {{(REG_W-1){1'b0}}, trig_flag};
            A_COUNT:  rd_data = REG_W'(count);
            default:  rd_data = '0;
        endcase
    end

    // R6
    run_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[0] |=> !$rose(trig_flag));

endmodule

// File: tb/tb_ext_trig_counter.sv
module tb_ext_trig_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        trig_flag;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ext_trig_counter dut (
        .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .trig_flag(trig_flag), .count(count)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    // chan: dir=01, filt, pol, src, psc
    function automatic logic [15:0] chan(input int src, input int filt, input logic pol,
                                         input int psc);
        return 16'((psc << 12) | (src << 8) | (int'(pol) << 6) | (filt << 2) | 1);
    endfunction

    task automatic setup(input int src, input int filt, input logic pol, input int psc);
        wr(3'd1, chan(src, filt, pol, psc));
        wr(3'd2, 16'h0067);
        wr(3'd0, 16'h0001);
        cyc(4 + filt);
    endtask

    task automatic pulse(input int src, input int width);
        @(negedge clk);
        src_in[src] = 1'b1;
        cyc(width);
        src_in[src] = 1'b0;
        cyc(24);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 reset register", v, 16'h0);
        end
        chk("R1 reset count", count, 16'h0);
        chk("R1 reset flag", 16'(trig_flag), 16'h0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(3'd1, 16'h3A65); rd(3'd1, v); chk("R2 chan readback", v, 16'h3A65);
        wr(3'd2, 16'h0067); rd(3'd2, v); chk("R2 slave readback", v, 16'h0067);
        wr(3'd0, 16'h0001); rd(3'd0, v); chk("R2 ctrl readback", v, 16'h0001);
        wr(3'd4, 16'h1234); rd(3'd4, v); chk("R2 count readback", v, 16'h1234);
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'h0000);
    endtask

    task automatic t_rise();
        logic [15:0] c0;
        setup(2, 0, 1'b0, 0);
        c0 = count;
        @(negedge clk);
        src_in[2] = 1'b1;
        cyc(3);
        chk("R3 no change after 3 edges", count, c0);
        cyc(1);
        chk("R3 +1 at fourth edge", count, c0 + 1);
        src_in[2] = 1'b0;
        cyc(10);
        chk("R3 falling edge not counted", count, c0 + 1);
    endtask

    task automatic t_fall();
        logic [15:0] c0;
        setup(2, 0, 1'b1, 0);
        c0 = count;
        @(negedge clk);
        src_in[2] = 1'b1;
        cyc(8);
        chk("R4 rising ignored", count, c0);
        src_in[2] = 1'b0;
        cyc(3);
        chk("R4 not yet", count, c0);
        cyc(1);
        chk("R4 falling counted", count, c0 + 1);
        cyc(6);
    endtask

    task automatic t_filter();
        logic [15:0] c0;
        setup(5, 3, 1'b0, 0);
        c0 = count;
        pulse(5, 2);
        chk("R5 short glitch ignored", count, c0);
        @(negedge clk);
        src_in[5] = 1'b1;
        cyc(6);
        chk("R5 not before 4+N", count, c0);
        cyc(1);
        chk("R5 counted at 4+N", count, c0 + 1);
        src_in[5] = 1'b0;
        cyc(12);
        pulse(5, 3);
        chk("R5 pulse of N samples counted", count, c0 + 2);
    endtask

    task automatic t_gating();
        logic [15:0] c0;
        setup(1, 0, 1'b0, 0);
        c0 = count;
        wr(3'd0, 16'h0000); pulse(1, 3);
        chk("R6 run off", count, c0);
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'h0102); pulse(1, 3);
        chk("R6 direction not input", count, c0);
        wr(3'd1, chan(1, 0, 1'b0, 0));
        wr(3'd2, 16'h0066); pulse(1, 3);
        chk("R6 wrong slave mode", count, c0);
        wr(3'd2, 16'h0057); pulse(1, 3);
        chk("R6 wrong trigger select", count, c0);
        wr(3'd2, 16'h0067); pulse(1, 3);
        chk("R6 all conditions met", count, c0 + 1);
    endtask

    task automatic t_source();
        logic [15:0] c0;
        setup(15, 0, 1'b0, 0);
        c0 = count;
        for (int s = 0; s < 15; s++) pulse(s, 2);
        chk("R7 other sources ignored", count, c0);
        pulse(15, 2);
        chk("R7 selected source counted", count, c0 + 1);
    endtask

    task automatic t_flag();
        logic [15:0] v;
        setup(3, 0, 1'b0, 0);
        wr(3'd3, 16'h0000);
        chk("R8 flag cleared", 16'(trig_flag), 16'h0);
        pulse(3, 2);
        rd(3'd3, v);
        chk("R8 flag set by edge", v, 16'h0001);
        wr(3'd3, 16'h0001);
        chk("R8 write 1 keeps flag", 16'(trig_flag), 16'h1);
        wr(3'd3, 16'hFFFE);
        chk("R8 write 0 clears flag", 16'(trig_flag), 16'h0);
    endtask

    task automatic t_psc();
        logic [15:0] c0;
        setup(4, 0, 1'b0, 3);
        c0 = count;
        for (int i = 0; i < 5; i++) pulse(4, 2);
        chk("R9 prescaler ignored", count, c0 + 5);
    endtask

    task automatic t_wrap();
        setup(6, 0, 1'b0, 0);
        wr(3'd4, 16'hFFFE);
        chk("R10 count written", count, 16'hFFFE);
        pulse(6, 2);
        chk("R10 reaches FFFF", count, 16'hFFFF);
        pulse(6, 2);
        chk("R10 wraps to zero", count, 16'h0000);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_regs();
        t_rise();
        t_fall();
        t_filter();
        t_gating();
        t_source();
        t_flag();
        t_psc();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule